// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address when the translation cache misses. It accepts one request at a time, carrying the virtual address, the kind of access and the physical address of the root table. It then makes two dependent reads of physical memory: first the entry in the top-level table, then the entry in the leaf table that the first entry points to. Its own reads are never translated.

A walk ends in exactly one of three ways. If either entry is marked not present, the walk reports a page fault. If the leaf is present but does not grant the requested access, the walk reports a protection fault. Otherwise the walk writes the translation into the translation cache and returns the physical address. The cache storage, the fault handler and the data caches are outside this block.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and mem_req_valid, cpl_valid and tlb_we are 0.
- R2: After a request is accepted, the first memory read goes to root_base + 4 × vaddr[31:22], and a read request holds its address steady while mem_req_ready is 0.
- R3: If bit 0 of the top-level entry is 0, the walk ends with cpl_page_fault, makes no second read and does not write the translation cache, whatever the entry's other bits hold.
- R4: The second read goes to {top-level entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R5: If bit 0 of the leaf entry is 0, the walk ends with cpl_page_fault and no cache write.
- R6: Leaf bits 1, 2 and 3 grant read, write and execute. Access code 0 is a load and needs read, 1 is a store and needs write, 2 is a fetch and needs execute, and 3 is always refused. A refused access ends with cpl_prot_fault and no cache write.
- R7: A permitted access pulses tlb_we with tlb_vpn = vaddr[31:12], tlb_ppn = leaf[31:12] and tlb_perm = leaf[3:1], and gives cpl_paddr = {leaf[31:12], vaddr[11:0]}.
- R8: Each accepted request gives exactly one one-cycle cpl_valid pulse, and in that cycle exactly one of tlb_we, cpl_page_fault and cpl_prot_fault is 1. All three are 0 outside the pulse.
- R9: req_ready is 1 only while no walk is in progress. A request presented during a walk is ignored: it neither changes the memory reads nor changes the result of the walk in progress.
- R10: The result does not depend on memory response latency or on cycles in which mem_req_ready is held low.
- R11: Bits 1 to 3 of the top-level entry have no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| root_base | input | 32 | Physical address of the top-level table |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry contents |
| cpl_valid | output | 1 | Walk finished (one-cycle pulse) |
| cpl_page_fault | output | 1 | Entry not present |
| cpl_prot_fault | output | 1 | Access not permitted |
| cpl_paddr | output | 32 | Translated physical address |
| tlb_we | output | 1 | Translation cache write |
| tlb_vpn | output | 20 | Virtual page number to store |
| tlb_ppn | output | 20 | Physical page number to store |
| tlb_perm | output | 3 | Execute, write, read permission to store |

## Verification
The assertions assume that memory returns exactly one response for each accepted read, never in the same cycle as the read is accepted and never while no read is outstanding. The bench memory model follows this rule. It counts down at least one cycle after each accepted read and then gives a single one-cycle response. Its latency and the number of cycles it holds mem_req_ready low are set per test, which covers both back-to-back and stalled reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT
    } walk_st_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_PERM_LO     = 1;
    localparam int PTE_PERM_W      = 3;
    localparam int LEVELS          = 2;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic [PA_W-1:0]  table_base,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int PAD_W = PA_W - IDX_W - 2;

    always_comb begin
        entry_addr = table_base + {{PAD_W{1'b0}}, index, 2'b00};
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [PTE_PERM_W:0] pte_low,
    input  logic [1:0]          access,
    output logic                present,
    output logic                allowed,
    output logic [PTE_PERM_W-1:0] perm
);
    always_comb begin
        present = pte_low[PTE_PRESENT_BIT];
        perm    = pte_low[PTE_PERM_LO +: PTE_PERM_W];
        unique case (access_e'(access))
            ACC_LOAD:  allowed = perm[0];
            ACC_STORE: allowed = perm[1];
            ACC_FETCH: allowed = perm[2];
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [2*IDX_W+OFF_W-1:0] req_vaddr,
    input  logic [1:0]              req_access,
    input  logic [PA_W-1:0]         root_base,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [PA_W-1:0]         mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [PA_W-1:0]         mem_rsp_data,
    output logic                    cpl_valid,
    output logic                    cpl_page_fault,
    output logic                    cpl_prot_fault,
    output logic [PA_W-1:0]         cpl_paddr,
    output logic                    tlb_we,
    output logic [2*IDX_W-1:0]      tlb_vpn,
    output logic [PA_W-OFF_W-1:0]   tlb_ppn,
    output logic [PTE_PERM_W-1:0]   tlb_perm
);
    localparam int VA_W  = 2*IDX_W + OFF_W;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    typedef struct packed {
        walk_st_e              st;
        logic [VA_W-1:0]       vaddr;
        logic [1:0]            acc;
        logic [PA_W-1:0]       base;
        logic                  cpl;
        logic                  pf;
        logic                  pv;
        logic                  we;
        logic [PPN_W-1:0]      ppn;
        logic [PTE_PERM_W-1:0] perm;
    } walk_reg_t;

    walk_reg_t r_q, r_d;

    // Entry address per level; level 0 uses the upper index field
    logic [PA_W-1:0] lvl_addr [LEVELS];
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        ptw_entry_addr #(.PA_W(PA_W), .IDX_W(IDX_W)) u_addr (
            .table_base (r_q.base),
            .index      (r_q.vaddr[OFF_W + IDX_W*(LEVELS-1-lv) +: IDX_W]),
            .entry_addr (lvl_addr[lv])
        );
    end

    logic                  pte_present;
    logic                  pte_allowed;
    logic [PTE_PERM_W-1:0] pte_perm;

    ptw_perm_check u_chk (
        .pte_low (mem_rsp_data[PTE_PERM_W:0]),
        .access  (r_q.acc),
        .present (pte_present),
        .allowed (pte_allowed),
        .perm    (pte_perm)
    );

    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^mem_rsp_data[OFF_W-1:PTE_PERM_W+1];

    always_comb begin
        r_d    = r_q;
        r_d.cpl = 1'b0;
        r_d.pf  = 1'b0;
        r_d.pv  = 1'b0;
        r_d.we  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr = req_vaddr;
                    r_d.acc   = req_access;
                    r_d.base  = root_base;
                    r_d.st    = ST_L1_REQ;
                end
            end
            ST_L1_REQ: begin
                if (mem_req_ready) r_d.st = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_present) begin
                        r_d.cpl = 1'b1;
                        r_d.pf  = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.base = {mem_rsp_data[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                        r_d.st   = ST_L2_REQ;
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_req_ready) r_d.st = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.cpl = 1'b1;
                    r_d.st  = ST_IDLE;
                    if (!pte_present) begin
                        r_d.pf = 1'b1;
                    end else if (!pte_allowed) begin
                        r_d.pv = 1'b1;
                    end else begin
                        r_d.we   = 1'b1;
                        r_d.ppn  = mem_rsp_data[PA_W-1:OFF_W];
                        r_d.perm = pte_perm;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready      = (r_q.st == ST_IDLE);
    assign mem_req_valid  = (r_q.st == ST_L1_REQ) || (r_q.st == ST_L2_REQ);
    assign mem_req_addr   = (r_q.st == ST_L2_REQ) ? lvl_addr[1] : lvl_addr[0];
    assign cpl_valid      = r_q.cpl;
    assign cpl_page_fault = r_q.pf;
    assign cpl_prot_fault = r_q.pv;
    assign tlb_we         = r_q.we;
    assign tlb_vpn        = r_q.vaddr[VA_W-1:OFF_W];
    assign tlb_ppn        = r_q.ppn;
    assign tlb_perm       = r_q.perm;
    assign cpl_paddr      = {r_q.ppn, r_q.vaddr[OFF_W-1:0]};

    // R1: nothing is pending out of reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> req_ready && !mem_req_valid && !cpl_valid);

    // R2: a stalled read keeps its address
    a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8: completion is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);

    // R8: exactly one outcome flag with each pulse
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $countones({tlb_we, cpl_page_fault, cpl_prot_fault}) == 1);

    // R8: outcome flags stay low without a pulse
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpl_valid |-> !tlb_we && !cpl_page_fault && !cpl_prot_fault);

    // R9: an accepted request makes the walker busy
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && mem_req_valid);

    // R9: no table read while idle
    a_r9_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // R7: refill is a completed walk and carries the returned page
    a_r7_refill_ppn: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_we |-> cpl_paddr[PA_W-1:OFF_W] == tlb_ppn && cpl_valid);

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        cpl_valid, cpl_page_fault, cpl_prot_fault, tlb_we;
    logic [31:0] cpl_paddr;
    logic [19:0] tlb_vpn, tlb_ppn;
    logic [2:0]  tlb_perm;

    always #2.5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_access(req_access), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .cpl_valid(cpl_valid), .cpl_page_fault(cpl_page_fault),
        .cpl_prot_fault(cpl_prot_fault), .cpl_paddr(cpl_paddr),
        .tlb_we(tlb_we), .tlb_vpn(tlb_vpn), .tlb_ppn(tlb_ppn), .tlb_perm(tlb_perm)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model
    logic [31:0] pmem [logic [31:0]];
    int          mem_lat = 1;
    int          mem_stall = 0;
    int          stall_left = 0;
    int          cnt = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] rd_log [4];
    int          n_rd = 0;

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 32'h0;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_read(pend_addr);
                end
            end
            if (mem_req_valid && rst_n) begin
                if (stall_left > 0) begin
                    mem_req_ready = 1'b0;
                    stall_left--;
                end else begin
                    mem_req_ready = 1'b1;
                    pend_addr = mem_req_addr;
                    if (n_rd < 4) rd_log[n_rd] = mem_req_addr;
                    n_rd++;
                    cnt = mem_lat;
                    stall_left = mem_stall;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    localparam logic [31:0] ROOT = 32'h0001_0000;

    function automatic logic [31:0] va(input int i1, input int i2, input int off);
        return (32'(i1) << 22) | (32'(i2) << 12) | 32'(off);
    endfunction

    function automatic logic [31:0] l1_addr(input logic [31:0] v);
        return ROOT + {20'd0, v[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [31:0] l1pte, input logic [31:0] v);
        return {l1pte[31:12], 12'h000} + {20'd0, v[21:12], 2'b00};
    endfunction

    // Outcome codes used only by the bench: 0 refill, 1 page fault, 2 protection fault
    task automatic walk(input logic [31:0] v, input logic [1:0] acc, input bit junk,
                        input int exp_kind, input int exp_reads, input string req);
        logic [31:0] p1, p2;
        bit seen;
        int  got_kind;
        bit  perm_ok;
        p1 = mem_read(l1_addr(v));
        p2 = mem_read(l2_addr(p1, v));
        @(negedge clk);
        n_rd = 0;
        req_vaddr = v; req_access = acc; root_base = ROOT; req_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            req_vaddr = v ^ 32'hFFC0_0000; req_access = ~acc; root_base = 32'h0F00_0000;
        end else begin
            req_valid = 1'b0;
        end
        seen = 1'b0;
        for (int t = 0; t < 400 && !seen; t++) begin
            if (cpl_valid) seen = 1'b1;
            else begin
                if (junk) chk(req_ready == 1'b0, "R9", "busy ready", {31'd0, req_ready}, 32'd0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(seen, "R8", "completion seen", {31'd0, seen}, 32'd1);
        got_kind = tlb_we ? 0 : cpl_page_fault ? 1 : cpl_prot_fault ? 2 : 3;
        chk(got_kind == exp_kind, req, "outcome", 32'(got_kind), 32'(exp_kind));
        chk(n_rd == exp_reads, req, "read count", 32'(n_rd), 32'(exp_reads));
        if (n_rd >= 1)
            chk(rd_log[0] == l1_addr(v), "R2", "first read address", rd_log[0], l1_addr(v));
        if (n_rd >= 2)
            chk(rd_log[1] == l2_addr(p1, v), "R4", "second read address", rd_log[1], l2_addr(p1, v));
        if (exp_kind == 0) begin
            chk(tlb_vpn == v[31:12], "R7", "tlb_vpn", {12'd0, tlb_vpn}, {12'd0, v[31:12]});
            chk(tlb_ppn == p2[31:12], "R7", "tlb_ppn", {12'd0, tlb_ppn}, {12'd0, p2[31:12]});
            chk(tlb_perm == p2[3:1], "R7", "tlb_perm", {29'd0, tlb_perm}, {29'd0, p2[3:1]});
            chk(cpl_paddr == {p2[31:12], v[11:0]}, "R7", "paddr", cpl_paddr, {p2[31:12], v[11:0]});
            perm_ok = (acc == 2'd0) ? p2[1] : (acc == 2'd1) ? p2[2] : (acc == 2'd2) ? p2[3] : 1'b0;
            chk(perm_ok, "R6", "permission model", {31'd0, perm_ok}, 32'd1);
        end
        @(negedge clk);
        chk(!cpl_valid && !tlb_we && !cpl_page_fault && !cpl_prot_fault, "R8", "pulse ends",
            {28'd0, cpl_valid, tlb_we, cpl_page_fault, cpl_prot_fault}, 32'd0);
        chk(req_ready && !mem_req_valid, "R9", "idle after walk",
            {30'd0, req_ready, mem_req_valid}, 32'd2);
        chk(n_rd == exp_reads, "R8", "no extra read", 32'(n_rd), 32'(exp_reads));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !cpl_valid && !tlb_we, "R1", "reset state",
            {28'd0, req_ready, mem_req_valid, cpl_valid, tlb_we}, 32'h8);
    endtask

    task automatic t_refill_load;    walk(va(3, 5, 12'hABC), 2'd0, 1'b0, 0, 2, "R7");  endtask
    task automatic t_l1_absent;      walk(va(7, 1, 12'h010), 2'd0, 1'b0, 1, 1, "R3");  endtask
    task automatic t_l1_absent_perm; walk(va(1023, 2, 12'h000), 2'd0, 1'b0, 1, 1, "R3"); endtask
    task automatic t_l2_absent;      walk(va(3, 9, 12'h444), 2'd0, 1'b0, 1, 2, "R5");  endtask
    task automatic t_store_denied;   walk(va(3, 5, 12'h001), 2'd1, 1'b0, 2, 2, "R6");  endtask
    task automatic t_fetch_ok;       walk(va(3, 6, 12'hFFF), 2'd2, 1'b0, 0, 2, "R6");  endtask
    task automatic t_store_on_rx;    walk(va(3, 6, 12'h123), 2'd1, 1'b0, 2, 2, "R6");  endtask
    task automatic t_reserved_acc;   walk(va(3, 5, 12'h000), 2'd3, 1'b0, 2, 2, "R6");  endtask
    task automatic t_l1_perm_ignored; walk(va(8, 1023, 12'h7E5), 2'd1, 1'b0, 0, 2, "R11"); endtask
    task automatic t_busy_ignored;   walk(va(3, 5, 12'h555), 2'd0, 1'b1, 0, 2, "R9");  endtask

    task automatic t_slow_memory;
        mem_lat = 6; mem_stall = 3; stall_left = 3;
        walk(va(3, 6, 12'h0A0), 2'd0, 1'b0, 0, 2, "R10");
        walk(va(3, 9, 12'h0A0), 2'd0, 1'b0, 1, 2, "R10");
        mem_lat = 1; mem_stall = 0; stall_left = 0;
    endtask

    initial begin
        pmem[ROOT + 32'd12]    = 32'h0002_0001;              // index 3 -> table 0x20000
        pmem[ROOT + 32'hFFC]   = 32'h0003_000E;              // index 1023: perms set, not present
        pmem[ROOT + 32'd32]    = 32'h0004_0001;              // index 8: present, no perm bits
        pmem[32'h0002_0014]    = 32'h1234_5003;              // read only
        pmem[32'h0002_0018]    = 32'hABCD_E00B;              // read and execute
        pmem[32'h0004_0FFC]    = 32'hFFFF_F00F;              // all permissions
        t_reset;
        t_refill_load;
        t_l1_absent;
        t_l1_absent_perm;
        t_l2_absent;
        t_store_denied;
        t_fetch_ok;
        t_store_on_rx;
        t_reserved_acc;
        t_l1_perm_ignored;
        t_busy_ignored;
        t_slow_memory;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule